// File: doc/BRIEF.md
# Event Framer with Control-Word Envelope

This block turns a stream of 32-bit payload words into a framed event for a serial readout link. It stores a whole event's payload in an internal buffer. When the word marked as last has been accepted, it sends the event out in this order: an opening control word, three header words, the stored payload, and a closing control word. Control words are sent with a separate flag raised next to the data bus. The header carries the event identification and status taken from side-band inputs, plus a 16-bit size. Because the whole payload is held, the size is known before the first header word leaves the block.

The size counts the three header words and every payload word. It does not count the two control words. A 10-bit source identifier is kept in a register that the host writes. Its value at the moment an event's last payload word is accepted goes into that event's header. The link can hold off the output with a full signal. While it is raised, the current word stays on the bus and nothing advances.

Only one event is handled at a time. Input is refused from the acceptance of the last payload word until the closing control word has been taken by the link.

Top module: `event_framer`

## Requirements
- R1: The first word of every frame is 0x00000000 with `out_ctrl` high. Its upper 28 bits hold the opening value 0, and its bits 3:0 hold the control nibble 0.
- R2: The last word of every frame is 0xCFED1200 with `out_ctrl` high. Bits 31:4 hold 0xCFED120 and bits 3:0 hold the control nibble 0. `out_ctrl` is low for every other word.
- R3: The 16-bit size field equals the number of payload words plus 3.
- R4: Frame word 1 carries bit 31 = 0, the event type in bits 30:26, the source identifier in bits 25:16 and the size in bits 15:0.
- R5: Frame word 2 carries bit 31 = 0, the spill number in bits 30:20 and the event number in bits 19:0.
- R6: Frame word 3 carries the format version in bits 31:24, the error-word count in bits 23:16, the trigger-system error code in bits 15:8 and the status in bits 7:0.
- R7: Payload words follow the third header word, in the order they were accepted and with their values unchanged.
- R8: While `link_full` is high, the word on `out_data`/`out_ctrl` is held and counts as not sent. Every frame word is delivered exactly once.
- R9: The source identifier is loaded by a `src_wr` pulse. A frame uses the value held when its last payload word was accepted. A write made while the frame is being sent shows up only in the next frame.
- R10: `in_ready` is low from the cycle after the last payload word is accepted until the closing control word has been sent. It is high again in the following cycle.
- R11: An event of exactly DEPTH payload words (64 by default) is accepted and framed with size DEPTH+3. An event of a single word gives size 4.
- R12: After reset `out_valid` is low, `in_ready` is high and the source identifier is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_wr | input | 1 | Load the source identifier register |
| src_wdata | input | 10 | New source identifier |
| evt_type | input | 5 | Event type, sampled with the last payload word |
| spill_num | input | 11 | Spill number, sampled with the last payload word |
| evt_num | input | 20 | Event number, sampled with the last payload word |
| fmt_ver | input | 8 | Format version, sampled with the last payload word |
| err_words | input | 8 | Error-word count, sampled with the last payload word |
| trig_err | input | 8 | Trigger-system error code, sampled with the last payload word |
| evt_status | input | 8 | Status byte, sampled with the last payload word |
| in_valid | input | 1 | Payload word present |
| in_ready | output | 1 | Framer can take a payload word |
| in_data | input | 32 | Payload word |
| in_last | input | 1 | Marks the final payload word of the event |
| out_valid | output | 1 | Frame word present |
| out_data | output | 32 | Frame word |
| out_ctrl | output | 1 | Frame word is a control word |
| link_full | input | 1 | Link cannot take a word this cycle |

## Verification
A wrong state register shows up at once on the first frame after it. The word sequence shifts, and a header word, payload word or control word appears at the wrong index, or `out_ctrl` lands on the wrong word. A wrong stored count shows in the size field one word after the opening control word. It also shows as a trailer that arrives early or late against the number of payload words sent. Errors in the read pointer or in stall handling show as a repeated or skipped payload word within the same frame. A source register fault shows in the next frame's word 1.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int          WORD_W      = 32;
    localparam int          SRC_W       = 10;
    localparam int          SIZE_W      = 16;
    localparam int          HDR_WORDS   = 3;
    localparam logic [27:0] OPEN_VAL    = 28'h0000000;
    localparam logic [27:0] CLOSE_VAL   = 28'hCFED120;
    localparam logic [3:0]  CTRL_NIBBLE = 4'h0;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_IDW,
        ST_SEQW,
        ST_STATW,
        ST_DATA,
        ST_CLOSE
    } frm_state_e;

    typedef struct packed {
        logic [4:0]  evt_type;
        logic [10:0] spill;
        logic [19:0] evt_num;
        logic [7:0]  fmt_ver;
        logic [7:0]  err_words;
        logic [7:0]  trig_err;
        logic [7:0]  status;
    } evt_meta_t;

    typedef struct packed {
        logic [WORD_W-1:0] id_w;
        logic [WORD_W-1:0] seq_w;
        logic [WORD_W-1:0] stat_w;
    } hdr_words_t;

    function automatic logic [WORD_W-1:0] ctrl_word(input logic [27:0] val);
        return {val, CTRL_NIBBLE};
    endfunction

    function automatic logic [SIZE_W-1:0] frame_size(input logic [SIZE_W-1:0] payload_n);
        return payload_n + SIZE_W'(HDR_WORDS);
    endfunction

    function automatic logic [WORD_W-1:0] make_id_word(input logic [4:0] typ,
                                                       input logic [SRC_W-1:0] src,
                                                       input logic [SIZE_W-1:0] sz);
        return {1'b0, typ, src, sz};
    endfunction

    function automatic logic [WORD_W-1:0] make_seq_word(input evt_meta_t m);
        return {1'b0, m.spill, m.evt_num};
    endfunction

    function automatic logic [WORD_W-1:0] make_stat_word(input evt_meta_t m);
        return {m.fmt_ver, m.err_words, m.trig_err, m.status};
    endfunction

endpackage

// File: rtl/payload_buffer.sv
module payload_buffer
    import framer_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_adv,
    input  logic              clear,
    output logic [CW-1:0]     count,
    output logic [WORD_W-1:0] rd_data,
    output logic              full
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     rd_ptr;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[count[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count  <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                count <= count + CW'(1);
            end
            if (rd_adv) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
        end
    end

    assign rd_data = mem[rd_ptr];
    assign full    = (count == CW'(DEPTH));

    // R11: the buffer never takes a word beyond its depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (count < CW'(DEPTH)));

endmodule

// File: rtl/meta_capture.sv
module meta_capture
    import framer_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             src_wr,
    input  logic [SRC_W-1:0] src_wdata,
    input  logic             capture,
    input  evt_meta_t        meta_in,
    input  logic [CW-1:0]    payload_n,
    output hdr_words_t       hdr
);

    logic [SRC_W-1:0]  src_reg;
    logic [SIZE_W-1:0] size_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_reg <= '0;
        end else if (src_wr) begin
            src_reg <= src_wdata;
        end
    end

    assign size_now = frame_size(SIZE_W'(payload_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr <= '0;
        end else if (capture) begin
            hdr.id_w   <= make_id_word(meta_in.evt_type, src_reg, size_now);
            hdr.seq_w  <= make_seq_word(meta_in);
            hdr.stat_w <= make_stat_word(meta_in);
        end
    end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import framer_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          last_fire,
    input  logic [CW-1:0] count,
    input  logic          link_full,
    output frm_state_e    state,
    output logic          out_valid,
    output logic          rd_adv,
    output logic          clear,
    output logic          in_open
);

    logic [CW-1:0] sent_cnt;
    logic          adv;
    logic          data_done;
    frm_state_e    nxt;

    assign out_valid = (state != ST_FILL);
    assign adv       = out_valid && !link_full;
    assign rd_adv    = adv && (state == ST_DATA);
    assign clear     = adv && (state == ST_CLOSE);
    assign in_open   = (state == ST_FILL);
    assign data_done = (sent_cnt == (count - CW'(1)));

    always_comb begin
        nxt = state;
        case (state)
            ST_FILL:  if (last_fire) nxt = ST_OPEN;
            ST_OPEN:  if (adv)       nxt = ST_IDW;
            ST_IDW:   if (adv)       nxt = ST_SEQW;
            ST_SEQW:  if (adv)       nxt = ST_STATW;
            ST_STATW: if (adv)       nxt = ST_DATA;
            ST_DATA:  if (adv && data_done) nxt = ST_CLOSE;
            ST_CLOSE: if (adv)       nxt = ST_FILL;
            default:                 nxt = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            sent_cnt <= '0;
        end else begin
            state <= nxt;
            if (clear) begin
                sent_cnt <= '0;
            end else if (rd_adv) begin
                sent_cnt <= sent_cnt + CW'(1);
            end
        end
    end

    // R7: payload reads never exceed the stored word count
    a_r7_reads_bounded: assert property (@(posedge clk) disable iff (rst)
        rd_adv |-> (sent_cnt < count));

    // R10: a frame only begins from the fill state on the last payload word
    a_r10_start_from_fill: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL && !last_fire) |=> (state == ST_FILL));

endmodule

// File: rtl/event_framer.sv
module event_framer
    import framer_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        src_wr,
    input  logic [9:0]  src_wdata,
    input  logic [4:0]  evt_type,
    input  logic [10:0] spill_num,
    input  logic [19:0] evt_num,
    input  logic [7:0]  fmt_ver,
    input  logic [7:0]  err_words,
    input  logic [7:0]  trig_err,
    input  logic [7:0]  evt_status,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_data,
    input  logic        in_last,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        out_ctrl,
    input  logic        link_full
);

    frm_state_e        state;
    logic              in_open;
    logic              buf_full;
    logic              in_fire;
    logic              last_fire;
    logic              rd_adv;
    logic              clear;
    logic [CW-1:0]     count;
    logic [WORD_W-1:0] rd_data;
    hdr_words_t        hdr;
    evt_meta_t         meta;

    assign in_ready  = in_open && !buf_full;
    assign in_fire   = in_valid && in_ready;
    assign last_fire = in_fire && in_last;

    assign meta = '{evt_type:  evt_type,
                    spill:     spill_num,
                    evt_num:   evt_num,
                    fmt_ver:   fmt_ver,
                    err_words: err_words,
                    trig_err:  trig_err,
                    status:    evt_status};

    payload_buffer #(.DEPTH(DEPTH)) buf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_fire),
        .wr_data (in_data),
        .rd_adv  (rd_adv),
        .clear   (clear),
        .count   (count),
        .rd_data (rd_data),
        .full    (buf_full)
    );

    meta_capture #(.CW(CW)) meta_i (
        .clk       (clk),
        .rst       (rst),
        .src_wr    (src_wr),
        .src_wdata (src_wdata),
        .capture   (last_fire),
        .meta_in   (meta),
        .payload_n (count + CW'(1)),
        .hdr       (hdr)
    );

    frame_sequencer #(.CW(CW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .last_fire (last_fire),
        .count     (count),
        .link_full (link_full),
        .state     (state),
        .out_valid (out_valid),
        .rd_adv    (rd_adv),
        .clear     (clear),
        .in_open   (in_open)
    );

    always_comb begin
        out_data = '0;
        out_ctrl = 1'b0;
        case (state)
            ST_OPEN: begin
                out_data = ctrl_word(OPEN_VAL);
                out_ctrl = 1'b1;
            end
            ST_IDW:   out_data = hdr.id_w;
            ST_SEQW:  out_data = hdr.seq_w;
            ST_STATW: out_data = hdr.stat_w;
            ST_DATA:  out_data = rd_data;
            ST_CLOSE: begin
                out_data = ctrl_word(CLOSE_VAL);
                out_ctrl = 1'b1;
            end
            default: ;
        endcase
    end

    // R8: a stalled word stays on the bus unchanged
    a_r8_hold_on_full: assert property (@(posedge clk) disable iff (rst)
        (out_valid && link_full) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

    // R10: payload input is closed while a frame is on the output
    a_r10_closed_while_sending: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R2: every control word carries the zero control nibble
    a_r2_ctrl_nibble: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ctrl) |-> (out_data[3:0] == 4'h0));

    // R1: the opening control word follows the last accepted payload word
    a_r1_open_after_last: assert property (@(posedge clk) disable iff (rst)
        last_fire |=> (out_valid && out_ctrl && out_data == 32'h0));

endmodule

// File: tb/event_framer_tb_top.sv
module event_framer_tb_top;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        src_wr;
    logic [9:0]  src_wdata;
    logic [4:0]  evt_type;
    logic [10:0] spill_num;
    logic [19:0] evt_num;
    logic [7:0]  fmt_ver, err_words, trig_err, evt_status;
    logic        in_valid, in_ready, in_last;
    logic [31:0] in_data;
    logic        out_valid, out_ctrl, link_full;
    logic [31:0] out_data;

    int errs   = 0;
    int checks = 0;
    logic [9:0] b_src;

    always #2 clk = ~clk;

    event_framer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .src_wr(src_wr), .src_wdata(src_wdata),
        .evt_type(evt_type), .spill_num(spill_num), .evt_num(evt_num),
        .fmt_ver(fmt_ver), .err_words(err_words), .trig_err(trig_err),
        .evt_status(evt_status), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_data(out_data), .out_ctrl(out_ctrl), .link_full(link_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit stall_at(input int mode, input int cyc);
        case (mode)
            1:       return (cyc % 2) == 1;
            2:       return (cyc % 5) < 2;
            default: return 1'b0;
        endcase
    endfunction

    task automatic host_write(input logic [9:0] v);
        @(negedge clk);
        src_wr = 1'b1; src_wdata = v;
        @(negedge clk);
        src_wr = 1'b0;
        b_src = v;
    endtask

    task automatic set_meta(input int seed);
        evt_type   = 5'(seed * 3 + 1);
        spill_num  = 11'(seed * 97 + 5);
        evt_num    = 20'(seed * 40503 + 7);
        fmt_ver    = 8'(seed + 8'h21);
        err_words  = 8'(seed * 5);
        trig_err   = 8'(8'hE0 ^ seed);
        evt_status = 8'(8'h5A + seed);
    endtask

    // Send one event of n words, then collect and check the whole frame.
    task automatic do_event(input int n, input int mode, input int seed,
                            input bit mid_write, input logic [9:0] mid_val);
        logic [31:0] exp_w [DEPTH+5];
        logic        exp_c [DEPTH+5];
        logic [31:0] held;
        bit          was_stalled;
        int          k, cyc, total;
        logic [9:0]  src_used;
        string       req;
        total = n + 5;
        set_meta(seed);
        src_used = b_src;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 32'hA5000000 ^ (seed << 16) ^ (i * 32'h01030507);
            in_last  = (i == n - 1);
            exp_w[4 + i] = in_data;
            exp_c[4 + i] = 1'b0;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        exp_w[0] = 32'h00000000; exp_c[0] = 1'b1;
        exp_w[1] = {1'b0, evt_type, src_used, 16'(n + 3)}; exp_c[1] = 1'b0;
        exp_w[2] = {1'b0, spill_num, evt_num}; exp_c[2] = 1'b0;
        exp_w[3] = {fmt_ver, err_words, trig_err, evt_status}; exp_c[3] = 1'b0;
        exp_w[n + 4] = 32'hCFED1200; exp_c[n + 4] = 1'b1;
        k = 0; cyc = 0; was_stalled = 1'b0; held = '0;
        while (k < total && cyc < 2000) begin
            link_full = stall_at(mode, cyc);
            if (mid_write) begin
                src_wr = (cyc == 0); src_wdata = mid_val;
            end
            if (out_valid) begin
                chk(!in_ready, "R10", "in_ready during frame", {31'b0, in_ready}, 32'h0);
                if (was_stalled)
                    chk(out_data == held, "R8", "word held under link_full", out_data, held);
                if (link_full) begin
                    held = out_data; was_stalled = 1'b1;
                end else begin
                    if (k == 0) req = "R1";
                    else if (k == 1) req = "R4/R3/R9";
                    else if (k == 2) req = "R5";
                    else if (k == 3) req = "R6";
                    else if (k == total - 1) req = "R2";
                    else req = "R7";
                    chk(out_data == exp_w[k], req, $sformatf("word %0d data", k), out_data, exp_w[k]);
                    chk(out_ctrl == exp_c[k], req, $sformatf("word %0d ctrl", k),
                        {31'b0, out_ctrl}, {31'b0, exp_c[k]});
                    was_stalled = 1'b0;
                    k++;
                end
            end
            @(negedge clk);
            cyc++;
        end
        link_full = 1'b0;
        if (mid_write) begin
            src_wr = 1'b0; b_src = mid_val;
        end
        if (k < total) chk(1'b0, "R8", "frame incomplete, words", k, total);
        chk(!out_valid, "R10", "out_valid after close", {31'b0, out_valid}, 32'h0);
        chk(in_ready, "R10", "in_ready after close", {31'b0, in_ready}, 32'h1);
    endtask

    task automatic t_reset_state();
        chk(!out_valid, "R12", "out_valid after reset", {31'b0, out_valid}, 32'h0);
        chk(in_ready, "R12", "in_ready after reset", {31'b0, in_ready}, 32'h1);
        b_src = 10'h000;
        do_event(2, 0, 1, 1'b0, 10'h0);   // R12: source id starts at 0
    endtask

    task automatic t_basic();
        host_write(10'h2B7);              // R9
        do_event(5, 0, 2, 1'b0, 10'h0);   // R3 R4 R5 R6 R7
    endtask

    task automatic t_single_word();
        do_event(1, 0, 3, 1'b0, 10'h0);   // R11 minimum size 4
    endtask

    task automatic t_full_depth();
        do_event(DEPTH, 0, 4, 1'b0, 10'h0);  // R11 size DEPTH+3
    endtask

    task automatic t_stalls();
        do_event(6, 1, 5, 1'b0, 10'h0);   // R8 alternating stall
        do_event(9, 2, 6, 1'b0, 10'h0);   // R8 burst stall
    endtask

    task automatic t_src_mid_write();
        do_event(3, 0, 7, 1'b1, 10'h3C1); // R9 current frame keeps old id
        do_event(3, 0, 8, 1'b0, 10'h0);   // R9 next frame uses new id
    endtask

    initial begin
        #800000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; src_wr = 1'b0; src_wdata = '0; in_valid = 1'b0; in_last = 1'b0;
        in_data = '0; link_full = 1'b0; b_src = '0;
        set_meta(0);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_single_word();
        t_full_depth();
        t_stalls();
        t_src_mid_write();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule